// File: doc/BRIEF.md
# Runtime-Configurable GF(2^m) Multiply and Reduce Unit

This unit performs arithmetic in a binary extension field whose degree m and irreducible polynomial are both supplied per operation instead of being fixed at build time. A multiply takes an accumulator operand and a second operand, forms their carry-less product one multiplier bit per cycle with on-the-fly reduction, and returns the reduced product. The result is meant to be written back over the accumulator register. A field add XORs the two operands and then reduces the sum modulo the polynomial one bit position per cycle. When the second source names register zero, the add becomes a pure modulo reduction of the accumulator.

The degree is taken either from a 5-bit immediate or from the low bits of a register, chosen by a select input. The modulus register holds the reduction polynomial: only its bits below the degree are read, and the bit at position m is always taken to be set. The unit handles one operation at a time. It raises busy while it iterates and pulses done for one cycle when the result is ready.

Top module: `gf2m_mulred`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all zero.
- R2: A start_i seen while busy_o is low is accepted and busy_o is high in the following cycle. A start_i seen while busy_o is high is ignored: the running operation's result and latency are unchanged, and no second operation follows it.
- R3: With op_i = 0 (multiply), result_o is the product of the two operands modulo the field polynomial, and it is always below 2^m.
- R4: A multiply ignores every bit of rs_i and ra_i at or above position m.
- R5: The field polynomial is x^m plus the bits of rb_i below position m. Bit m and all higher bits of rb_i have no effect.
- R6: With op_i = 1 (add), result_o is (rs_i XOR ra_i) fully reduced modulo the field polynomial, including rs_i bits far above m.
- R7: When ra_zero_i is 1, the second operand is taken as zero regardless of ra_i. An add then returns rs_i mod the polynomial, and a multiply returns zero.
- R8: With deg_src_i = 0, m is deg_imm_i (5 bits). With deg_src_i = 1, m is deg_reg_i (6 bits, up to 63).
- R9: busy_o stays high for exactly max(m,1) cycles for a multiply and 64 - m cycles for an add.
- R10: done_o is high for exactly one cycle, in the first cycle busy_o is low again. result_o changes only in that cycle and holds until the next completion. Operand inputs are sampled only when a start is accepted.
- R11: Degree m = 0 gives result_o = 0 for both operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 1 | 0 = multiply, 1 = add/reduce |
| deg_src_i | input | 1 | 0 = degree from immediate, 1 = degree from register |
| deg_imm_i | input | 5 | Immediate degree |
| deg_reg_i | input | 6 | Register degree (low bits of the degree register) |
| rs_i | input | 64 | Accumulator operand |
| ra_i | input | 64 | Second operand |
| ra_zero_i | input | 1 | Second source is register zero: use literal zero |
| rb_i | input | 64 | Modulus polynomial, bit m implied |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result of the last completed operation |

## Verification
The hardest situation to reach from the ports is a start request arriving in the middle of an operation with different operands and a different opcode. The stimulus raises start_i on the second busy cycle of a long operation and scrambles every operand input at the same time. It then checks that the original result and latency are kept and that busy_o stays low afterwards. Wide reductions are also hard to reach, because they need accumulator bits far above a small degree. Random 64-bit operands combined with random degrees, plus directed cases at degrees 0, 1, 3, 8 and 63, cover that span.

// File: rtl/gf2m_pkg.sv
// Shared types for the GF(2^m) multiply/reduce unit.
package gf2m_pkg;
    // Operation selector as carried on op_i
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_ADD = 1'b1
    } gf_op_e;

    // Sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gf_state_e;
endpackage

// File: rtl/gf2m_ctrl.sv
// Sequencer: accepts a start only while idle, loads the iteration count
// (max(m,1) for multiply, W-m for add), counts down one step per cycle
// and raises a one-cycle done pulse after the last step.
// Assumes deg_i < W.
module gf2m_ctrl
    import gf2m_pkg::*;
#(
    parameter int W     = 64,
    parameter int DEG_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  gf_op_e           op_i,
    input  logic [DEG_W-1:0] deg_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic             last_o,
    output logic [CNT_W-1:0] cnt_o
);
    gf_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_init;
    logic             done_q;

    assign load_o = start_i && (state_q == ST_IDLE);
    assign busy_o = (state_q == ST_RUN);
    assign last_o = busy_o && (cnt_q == CNT_W'(1));
    assign done_o = done_q;
    assign cnt_o  = cnt_q;

    // Number of steps the requested operation needs
    always_comb begin
        if (op_i == OP_ADD)
            cnt_init = CNT_W'(W) - CNT_W'(deg_i);
        else if (deg_i == '0)
            cnt_init = CNT_W'(1);
        else
            cnt_init = CNT_W'(deg_i);
    end

    // State, step counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                state_q <= ST_RUN;
                cnt_q   <= cnt_init;
            end else if (busy_o) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (last_o) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gf2m_mul_step.sv
// One shift-and-add multiply iteration: conditionally folds the
// multiplicand into the product, shifts the multiplicand up by one and
// reduces it when it reaches x^m. Assumes mcand_i < 2^m and rconst_i < 2^m.
module gf2m_mul_step #(
    parameter int W     = 64,
    parameter int DEG_W = 6
) (
    input  logic [W-1:0]     prod_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [W-1:0]     mplier_i,
    input  logic [W-1:0]     lowmask_i,
    input  logic [W-1:0]     rconst_i,
    input  logic [DEG_W-1:0] deg_i,
    output logic [W-1:0]     prod_o,
    output logic [W-1:0]     mcand_o,
    output logic [W-1:0]     mplier_o
);
    logic [W-1:0] shifted;
    logic         overflow;

    // Accumulate, shift and reduce in one combinational step
    always_comb begin
        prod_o   = mplier_i[0] ? (prod_i ^ mcand_i) : prod_i;
        shifted  = mcand_i << 1;
        overflow = shifted[deg_i];
        mcand_o  = (shifted & lowmask_i) ^ (overflow ? rconst_i : '0);
        mplier_o = mplier_i >> 1;
    end
endmodule

// File: rtl/gf2m_red_step.sv
// One long-division reduction step: examines bit (m + off) of the residue
// and, if it is set, clears it and folds in the reduction constant
// shifted by off. Assumes m + off < W and rconst_i < 2^m.
module gf2m_red_step #(
    parameter int W     = 64,
    parameter int DEG_W = 6,
    parameter int CNT_W = 7
) (
    input  logic [W-1:0]     acc_i,
    input  logic [W-1:0]     rconst_i,
    input  logic [DEG_W-1:0] deg_i,
    input  logic [CNT_W-1:0] off_i,
    output logic [W-1:0]     acc_o
);
    logic [CNT_W-1:0] pos;
    logic             hit;

    // Test the examined bit and cancel it against the shifted modulus
    always_comb begin
        pos   = CNT_W'(deg_i) + off_i;
        hit   = acc_i[pos[DEG_W-1:0]];
        acc_o = hit ? ((acc_i & ~(W'(1) << pos)) ^ (rconst_i << off_i)) : acc_i;
    end
endmodule

// File: rtl/gf2m_mulred.sv
// GF(2^m) multiply / add-reduce unit with runtime degree and polynomial.
// Multiply: one multiplier bit per cycle, operands masked below m.
// Add: XOR of the operands, then one reduction bit per cycle from bit W-1
// down to bit m. The result register updates with the done pulse.
// Assumes IMM_W <= DEG_W.
module gf2m_mulred
    import gf2m_pkg::*;
#(
    parameter  int W     = 64,
    parameter  int IMM_W = 5,
    localparam int DEG_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic             deg_src_i,
    input  logic [IMM_W-1:0] deg_imm_i,
    input  logic [DEG_W-1:0] deg_reg_i,
    input  logic [W-1:0]     rs_i,
    input  logic [W-1:0]     ra_i,
    input  logic             ra_zero_i,
    input  logic [W-1:0]     rb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     result_o
);
    localparam int CNT_W = DEG_W + 1;

    gf_op_e           op_in;
    logic [DEG_W-1:0] deg_sel;
    logic [W-1:0]     mask_in;
    logic [W-1:0]     ra_eff;

    gf_op_e           op_q;
    logic [DEG_W-1:0] deg_q;
    logic [W-1:0]     lowmask_q;
    logic [W-1:0]     rconst_q;
    logic [W-1:0]     acc_q;
    logic [W-1:0]     mcand_q;
    logic [W-1:0]     mplier_q;
    logic [W-1:0]     result_q;

    logic             load;
    logic             last;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     prod_n;
    logic [W-1:0]     mcand_n;
    logic [W-1:0]     mplier_n;
    logic [W-1:0]     red_n;
    logic [W-1:0]     acc_next;

    // Decode the request: degree source, low mask and effective second operand
    always_comb begin
        op_in   = gf_op_e'(op_i);
        deg_sel = deg_src_i ? deg_reg_i : DEG_W'(deg_imm_i);
        mask_in = (W'(1) << deg_sel) - W'(1);
        ra_eff  = ra_zero_i ? '0 : ra_i;
    end

    gf2m_ctrl #(
        .W     (W),
        .DEG_W (DEG_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_in),
        .deg_i   (deg_sel),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .load_o  (load),
        .last_o  (last),
        .cnt_o   (cnt)
    );

    gf2m_mul_step #(
        .W     (W),
        .DEG_W (DEG_W)
    ) u_mul (
        .prod_i    (acc_q),
        .mcand_i   (mcand_q),
        .mplier_i  (mplier_q),
        .lowmask_i (lowmask_q),
        .rconst_i  (rconst_q),
        .deg_i     (deg_q),
        .prod_o    (prod_n),
        .mcand_o   (mcand_n),
        .mplier_o  (mplier_n)
    );

    gf2m_red_step #(
        .W     (W),
        .DEG_W (DEG_W),
        .CNT_W (CNT_W)
    ) u_red (
        .acc_i    (acc_q),
        .rconst_i (rconst_q),
        .deg_i    (deg_q),
        .off_i    (cnt - CNT_W'(1)),
        .acc_o    (red_n)
    );

    // Pick the step result that matches the latched operation
    always_comb begin
        acc_next = (op_q == OP_MUL) ? prod_n : red_n;
    end

    // Operand capture on accept, iteration while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_MUL;
            deg_q     <= '0;
            lowmask_q <= '0;
            rconst_q  <= '0;
            acc_q     <= '0;
            mcand_q   <= '0;
            mplier_q  <= '0;
        end else if (load) begin
            op_q      <= op_in;
            deg_q     <= deg_sel;
            lowmask_q <= mask_in;
            rconst_q  <= rb_i & mask_in;
            if (op_in == OP_MUL) begin
                acc_q    <= '0;
                mcand_q  <= rs_i & mask_in;
                mplier_q <= ra_eff & mask_in;
            end else begin
                acc_q    <= rs_i ^ ra_eff;
                mcand_q  <= '0;
                mplier_q <= '0;
            end
        end else if (busy_o) begin
            acc_q    <= acc_next;
            mcand_q  <= mcand_n;
            mplier_q <= mplier_n;
        end
    end

    // Result register, written together with the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (last)
            result_q <= acc_next;
    end

    assign result_o = result_q;
endmodule

// File: rtl/gf2m_mulred_chk.sv
// Protocol and timing checker for gf2m_mulred. It keeps its own copy of
// the accepted degree and of the expected step count, and counts busy
// cycles independently of the design's counter.
module gf2m_mulred_chk #(
    parameter  int W     = 64,
    parameter  int IMM_W = 5,
    localparam int DEG_W = $clog2(W),
    localparam int CNT_W = DEG_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             op_i,
    input logic             deg_src_i,
    input logic [IMM_W-1:0] deg_imm_i,
    input logic [DEG_W-1:0] deg_reg_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [W-1:0]     result_o
);
    logic [DEG_W-1:0] deg_pick;
    logic [DEG_W-1:0] deg_q;
    logic [CNT_W-1:0] exp_d;
    logic [CNT_W-1:0] exp_q;
    logic [CNT_W-1:0] lat_q;

    // Expected busy length for the request on the inputs
    always_comb begin
        deg_pick = deg_src_i ? deg_reg_i : DEG_W'(deg_imm_i);
        if (op_i)
            exp_d = CNT_W'(W) - CNT_W'(deg_pick);
        else
            exp_d = (deg_pick == '0) ? CNT_W'(1) : CNT_W'(deg_pick);
    end

    // Capture accepted request and count busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deg_q <= '0;
            exp_q <= '0;
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            deg_q <= deg_pick;
            exp_q <= exp_d;
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + CNT_W'(1);
        end
    end

    // R2: an idle start makes the unit busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done only directly after a busy cycle, with busy already low
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R10: result holds outside the done cycle
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R3: a completed result lies below 2^m
    p_result_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o >> deg_q) == '0));

    // R9: busy length matches the operation and degree
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == exp_q));
endmodule

bind gf2m_mulred gf2m_mulred_chk #(
    .W     (W),
    .IMM_W (IMM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .deg_src_i (deg_src_i),
    .deg_imm_i (deg_imm_i),
    .deg_reg_i (deg_reg_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o)
);

// File: tb/tb_gf2m_mulred.sv
// Self-checking bench: directed corner cases plus seeded random operations,
// compared against reference functions (full carry-less product followed
// by polynomial long division).
module tb_gf2m_mulred;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic        deg_src_i = 1'b0;
    logic [4:0]  deg_imm_i = '0;
    logic [5:0]  deg_reg_i = '0;
    logic [63:0] rs_i = '0;
    logic [63:0] ra_i = '0;
    logic        ra_zero_i = 1'b0;
    logic [63:0] rb_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gf2m_mulred dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .deg_src_i (deg_src_i),
        .deg_imm_i (deg_imm_i),
        .deg_reg_i (deg_reg_i),
        .rs_i      (rs_i),
        .ra_i      (ra_i),
        .ra_zero_i (ra_zero_i),
        .rb_i      (rb_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] ref_reduce(logic [127:0] x, logic [63:0] rb, int deg);
        logic [127:0] poly;
        poly = {64'd0, rb & ((64'd1 << deg) - 64'd1)} | (128'd1 << deg);
        for (int k = 127; k >= deg; k--)
            if (x[k]) x = x ^ (poly << (k - deg));
        return x[63:0];
    endfunction

    function automatic logic [63:0] ref_mul(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] rb, int deg);
        logic [63:0]  m;
        logic [127:0] p;
        m = (64'd1 << deg) - 64'd1;
        a = a & m;
        b = b & m;
        p = '0;
        for (int i = 0; i < 64; i++)
            if (b[i]) p = p ^ ({64'd0, a} << i);
        return ref_reduce(p, rb, deg);
    endfunction

    function automatic logic [63:0] ref_add(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] rb, int deg);
        return ref_reduce({64'd0, a ^ b}, rb, deg);
    endfunction

    function automatic int exp_lat(logic op, int deg);
        if (op) return 64 - deg;
        return (deg == 0) ? 1 : deg;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one operation, scramble inputs while it runs, wait for done.
    task automatic run_op(input logic op, input logic dsrc, input logic [4:0] dimm,
                          input logic [5:0] dreg, input logic [63:0] rs,
                          input logic [63:0] ra, input logic raz,
                          input logic [63:0] rb, input bit inject,
                          output logic [63:0] res, output int lat);
        @(negedge clk);
        op_i = op; deg_src_i = dsrc; deg_imm_i = dimm; deg_reg_i = dreg;
        rs_i = rs; ra_i = ra; ra_zero_i = raz; rb_i = rb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rs_i = rnd64(); ra_i = rnd64(); rb_i = rnd64();
        deg_imm_i = 5'($urandom); deg_reg_i = 6'($urandom);
        check(busy_o == 1'b1, "R2 busy after accepted start", 64'(busy_o), 64'd1);
        lat = 0;
        while (!done_o && lat < 200) begin
            if (busy_o) lat++;
            if (inject && lat == 2) begin
                start_i = 1'b1; op_i = ~op; ra_zero_i = ~raz;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (lat >= 200) check(1'b0, "R9 watchdog waiting for done", 64'(lat), 64'd0);
        res = result_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] res;
        logic [63:0] res2;
        logic [63:0] exp;
        int          lat;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
        check(done_o == 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
        check(result_o == 64'd0, "R1 result after reset", result_o, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R9: degree 3, x^3+x+1, 0b111 * 0b101 = 0b110
        run_op(1'b0, 1'b0, 5'd3, 6'd0, 64'h7, 64'h5, 1'b0, 64'hB, 1'b0, res, lat);
        check(res == 64'h6, "R3 GF(8) product", res, 64'h6);
        check(lat == 3, "R9 multiply latency m=3", 64'(lat), 64'd3);

        // R3: degree 8, polynomial 0x11B, 0x80 * 0x83
        exp = ref_mul(64'h80, 64'h83, 64'h11B, 8);
        run_op(1'b0, 1'b0, 5'd8, 6'd0, 64'h80, 64'h83, 1'b0, 64'h11B, 1'b0, res, lat);
        check(res == exp, "R3 GF(256) product", res, exp);

        // R5: top bit absent and junk above m in the modulus
        run_op(1'b0, 1'b0, 5'd8, 6'd0, 64'h80, 64'h83, 1'b0, 64'hABCD_0000_0000_FE1B,
               1'b0, res2, lat);
        check(res2 == exp, "R5 modulus bits at/above m ignored", res2, exp);

        // R4: junk above m in both operands
        run_op(1'b0, 1'b0, 5'd8, 6'd0, 64'hFFFF_0000_1234_5680, 64'h8000_0000_0000_0F83,
               1'b0, 64'h11B, 1'b0, res, lat);
        check(res == exp, "R4 operand bits at/above m ignored", res, exp);

        // R8: register source selects 8 although the immediate holds 3
        run_op(1'b0, 1'b1, 5'd3, 6'd8, 64'h80, 64'h83, 1'b0, 64'h11B, 1'b0, res, lat);
        check(res == exp, "R8 degree from register", res, exp);
        check(lat == 8, "R8 register degree latency", 64'(lat), 64'd8);
        exp = ref_mul(64'hE7, 64'hB5, 64'h0B, 3);
        run_op(1'b0, 1'b0, 5'd3, 6'd40, 64'hE7, 64'hB5, 1'b0, 64'h0B, 1'b0, res, lat);
        check(res == exp, "R8 degree from immediate", res, exp);

        // R3 R9: full width degree 63
        begin
            logic [63:0] a, b, p;
            a = rnd64(); b = rnd64(); p = rnd64();
            exp = ref_mul(a, b, p, 63);
            run_op(1'b0, 1'b1, 5'd0, 6'd63, a, b, 1'b0, p, 1'b0, res, lat);
            check(res == exp, "R3 multiply m=63", res, exp);
            check(lat == 63, "R9 multiply latency m=63", 64'(lat), 64'd63);
        end

        // R11: degree zero
        run_op(1'b0, 1'b0, 5'd0, 6'd0, 64'hFFFF, 64'hFFFF, 1'b0, 64'hF, 1'b0, res, lat);
        check(res == 64'd0, "R11 multiply m=0", res, 64'd0);
        check(lat == 1, "R9 multiply latency m=0", 64'(lat), 64'd1);
        run_op(1'b1, 1'b0, 5'd0, 6'd0, 64'hDEAD_BEEF, 64'h1, 1'b0, 64'hF, 1'b0, res, lat);
        check(res == 64'd0, "R11 add m=0", res, 64'd0);
        check(lat == 64, "R9 add latency m=0", 64'(lat), 64'd64);

        // R6: add with no reduction needed, then with wide operands
        run_op(1'b1, 1'b0, 5'd8, 6'd0, 64'h57, 64'h83, 1'b0, 64'h11B, 1'b0, res, lat);
        check(res == 64'hD4, "R6 add below m", res, 64'hD4);
        check(lat == 56, "R9 add latency m=8", 64'(lat), 64'd56);
        exp = ref_add(64'hDEAD_BEEF_1234_5678, 64'h0F0F_0000_FFFF_0001, 64'h11B, 8);
        run_op(1'b1, 1'b0, 5'd8, 6'd0, 64'hDEAD_BEEF_1234_5678, 64'h0F0F_0000_FFFF_0001,
               1'b0, 64'h11B, 1'b0, res, lat);
        check(res == exp, "R6 add with wide reduction", res, exp);
        exp = ref_add(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h3, 1);
        run_op(1'b1, 1'b1, 5'd0, 6'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 64'h3, 1'b0,
               res, lat);
        check(res == exp, "R6 add m=1", res, exp);

        // R7: second source is register zero
        exp = ref_add(64'h1234_5678_9ABC_DEF0, 64'd0, 64'h11D, 8);
        run_op(1'b1, 1'b0, 5'd8, 6'd0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF, 1'b1,
               64'h11D, 1'b0, res, lat);
        check(res == exp, "R7 modulo pseudo-operation", res, exp);
        run_op(1'b0, 1'b0, 5'd8, 6'd0, 64'h55, 64'hFF, 1'b1, 64'h11D, 1'b0, res, lat);
        check(res == 64'd0, "R7 multiply by register zero", res, 64'd0);

        // R2: start during a busy multiply is ignored
        exp = ref_mul(64'hC3, 64'h9A, 64'h11B, 8);
        run_op(1'b0, 1'b0, 5'd8, 6'd0, 64'hC3, 64'h9A, 1'b0, 64'h11B, 1'b1, res, lat);
        check(res == exp, "R2 result unaffected by start while busy", res, exp);
        check(lat == 8, "R2 latency unaffected by start while busy", 64'(lat), 64'd8);
        check(busy_o == 1'b1 && done_o == 1'b1 ? 1'b0 : 1'b1, "R10 busy low with done",
              64'(busy_o), 64'd0);

        // R10: one-cycle done, result held while inputs change
        @(negedge clk);
        check(done_o == 1'b0, "R10 done is one cycle", 64'(done_o), 64'd0);
        check(busy_o == 1'b0, "R2 ignored start did not run later", 64'(busy_o), 64'd0);
        for (int i = 0; i < 5; i++) begin
            rs_i = rnd64(); ra_i = rnd64(); rb_i = rnd64();
            @(negedge clk);
        end
        check(result_o == exp, "R10 result held after completion", result_o, exp);

        // Seeded random mix
        for (int i = 0; i < 300; i++) begin
            logic        op, ds, rz;
            logic [4:0]  di;
            logic [5:0]  dr;
            logic [63:0] a, b, p;
            int          d;
            op = 1'($urandom); ds = 1'($urandom); rz = (($urandom % 8) == 0);
            di = 5'($urandom); dr = 6'($urandom);
            a = rnd64(); b = rnd64(); p = rnd64();
            d = ds ? int'(dr) : int'(di);
            exp = op ? ref_add(a, rz ? 64'd0 : b, p, d) : ref_mul(a, rz ? 64'd0 : b, p, d);
            run_op(op, ds, di, dr, a, b, rz, p, 1'b0, res, lat);
            check(res == exp, op ? "R6 random add" : "R3 random multiply", res, exp);
            check(lat == exp_lat(op, d), "R9 random latency", 64'(lat),
                  64'(exp_lat(op, d)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule